// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is the 8-bit power-management control register of a small microcontroller, together with the sequencing logic behind it. The CPU writes one byte to it. Some bits of that byte are one-shot commands: they request sleep, stop or time-base-timer mode, or they fire a short internal reset. The other bits are stored settings: whether the pins float during the deep modes, and how long the CPU clock is held off on each peripheral access in intermittent operation. The stored bits read back. The command bits always read back as their inactive values.

A low-power mode, once entered, stays latched until a single wake-up input (`cancel_i`) is asserted. The block then returns to run mode and releases the pin high-impedance control. A peripheral access request drops the CPU clock enable for 0, 8, 16 or 32 cycles, as set by the halt-cycle field. All state is clocked on `clk` and cleared by the synchronous active-low `rst_n`.

Top module: `pwrmode_ctl`

## Requirements
- R1: After reset the register reads 8'h18, no mode output is active, `int_rst_o` is 0, `cpu_clk_en_o` is 1 and `pin_hiz_o` is 0.
- R2: Read-back format: bit 5 returns the stored pin-float setting and bits 2:1 return the stored halt code. Bits 7 and 6 read 0, bits 4 and 3 read 1, and bit 0 reads 0 whatever was written to it.
- R3: A write with bit 4 = 0 drives `int_rst_o` high for exactly 3 consecutive cycles, starting in the cycle after the write. A new trigger during a pulse restarts the 3-cycle count. A write with bit 4 = 1 starts no pulse.
- R4: From run mode, a write with bit 7 = 1 enters stop, a write with bit 3 = 0 enters time-base-timer mode, and a write with bit 6 = 1 enters sleep. Each takes effect in the cycle after the write. The opposite values of these bits change nothing.
- R5: When one write requests more than one mode, stop wins over time-base-timer, which wins over sleep. At most one mode output is high at any time. Mode requests that arrive while a mode is already active are ignored.
- R6: `pin_hiz_o` equals the stored bit 5 while stop or time-base-timer mode is active. It is 0 in sleep and in run mode.
- R7: When `cancel_i` is high while a mode is active, the block returns to run mode at the next edge and `pin_hiz_o` falls. When `cancel_i` is high in run mode, nothing changes.
- R8: Halt code 00 gives 0 cycles, 01 gives 8, 10 gives 16 and 11 gives 32. A `periph_req_i` sampled while the enable is high and the code is nonzero drops `cpu_clk_en_o` for exactly that many cycles, starting in the next cycle. Requests made during a hold are ignored, and with code 00 the enable never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register read-back value |
| cancel_i | input | 1 | Wake-up request that ends an active mode |
| periph_req_i | input | 1 | Peripheral access request that starts a CPU clock hold |
| mode_sleep_o | output | 1 | Sleep mode active |
| mode_stop_o | output | 1 | Stop mode active |
| mode_tbt_o | output | 1 | Time-base-timer mode active |
| pin_hiz_o | output | 1 | Pins float (high impedance) |
| int_rst_o | output | 1 | Internal reset pulse |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The bench targets the exact length of the reset pulse. A counter off by one would give a 2- or 4-cycle pulse, and a pulse started on the write edge itself would show up one cycle early. It drives writes that request several modes at once and writes that arrive while a mode is already active, so a wrong priority order, or a mode that is re-entered while another one holds, shows up on the mode outputs. It measures the 32-cycle hold and sends requests in the middle of a hold: a design that reloads its counter during a hold would stretch the hold. It also checks that the pins float only in the two deep modes and that bit 0 and the command bits never read back as written.

// File: rtl/pwrmode_pkg.sv
// Shared types and bit positions for the low-power mode control register.
// Assumes an 8-bit register; bit positions are fixed because software decodes them.
package pwrmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_SLEEP = 2'd1,
        PM_STOP  = 2'd2,
        PM_TBT   = 2'd3
    } pm_mode_e;

    localparam int BIT_STOP    = 7;
    localparam int BIT_SLEEP   = 6;
    localparam int BIT_HIZ     = 5;
    localparam int BIT_RSTN    = 4;
    localparam int BIT_TBTN    = 3;
    localparam int BIT_HALT_HI = 2;
    localparam int BIT_HALT_LO = 1;
    localparam int REG_W       = 8;

    localparam logic [REG_W-1:0] CTRL_RESET = 8'h18;

endpackage

// File: rtl/pwrmode_regs.sv
// Stored fields of the control register (pin-float bit and halt code) and the
// read-back word. Command bits are not stored and read as their inactive values.
// Assumes writes are single-cycle strobes.
module pwrmode_regs
    import pwrmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             hiz,
    output logic [1:0]       halt_code,
    output logic [REG_W-1:0] rd_data
);

    // Capture the stored fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz       <= 1'b0;
            halt_code <= 2'b00;
        end else if (wr_en) begin
            hiz       <= wr_data[BIT_HIZ];
            halt_code <= wr_data[BIT_HALT_HI:BIT_HALT_LO];
        end
    end

    // Build the read-back word: stored fields plus fixed command-bit values.
    always_comb begin
        rd_data              = CTRL_RESET;
        rd_data[BIT_STOP]    = 1'b0;
        rd_data[BIT_SLEEP]   = 1'b0;
        rd_data[BIT_HIZ]     = hiz;
        rd_data[BIT_RSTN]    = 1'b1;
        rd_data[BIT_TBTN]    = 1'b1;
        rd_data[BIT_HALT_HI:BIT_HALT_LO] = halt_code;
        rd_data[0]           = 1'b0;
    end

endmodule

// File: rtl/pwrmode_seq.sv
// Low-power mode state machine. Accepts a request only in run mode, resolves
// simultaneous requests as stop > time-base-timer > sleep, and leaves the mode on cancel.
// Assumes the request lines are qualified by wr_en.
module pwrmode_seq
    import pwrmode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     req_stop,
    input  logic     req_tbt,
    input  logic     req_sleep,
    input  logic     cancel,
    output pm_mode_e mode
);

    // Advance the mode: leave on cancel, enter on a prioritized request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= PM_RUN;
        end else if (mode != PM_RUN) begin
            if (cancel) mode <= PM_RUN;
        end else if (wr_en) begin
            if (req_stop)       mode <= PM_STOP;
            else if (req_tbt)   mode <= PM_TBT;
            else if (req_sleep) mode <= PM_SLEEP;
        end
    end

    AST_CANCEL_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN && cancel) |=> (mode == PM_RUN)); // R7

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && wr_en && req_stop) |=> (mode == PM_STOP)); // R5

    AST_TBT_OVER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && wr_en && !req_stop && req_tbt) |=> (mode == PM_TBT)); // R5

    AST_NO_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) != PM_RUN && mode != PM_RUN) |-> (mode == $past(mode))); // R5

endmodule

// File: rtl/pwrmode_pulse.sv
// Fixed-length internal reset pulse generator. A trigger (re)starts a pulse of
// LEN cycles beginning in the next cycle. Assumes LEN >= 1.
module pwrmode_pulse #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_o
);

    generate
        if (LEN == 1) begin : g_single
            logic q;
            // A one-cycle pulse needs only a flop.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= fire;
            end
            assign pulse_o = q;
        end else begin : g_count
            localparam int CW = $clog2(LEN + 1);
            logic [CW-1:0] cnt;
            // Load the pulse length on a trigger and count it down.
            always_ff @(posedge clk) begin
                if (!rst_n)          cnt <= '0;
                else if (fire)       cnt <= CW'(LEN);
                else if (cnt != '0)  cnt <= cnt - 1'b1;
            end
            assign pulse_o = (cnt != '0);
        end
    endgenerate

    AST_PULSE_HAS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire)); // R3

endmodule

// File: rtl/pwrmode_hold.sv
// CPU clock hold-off for intermittent operation. A peripheral request sampled
// while idle drops the enable for 0, BASE, 2*BASE or 4*BASE cycles, as set by the code.
// Assumes requests during a hold are to be ignored.
module pwrmode_hold #(
    parameter int HALT_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] code,
    output logic       clk_en
);

    localparam int MAX_LEN = HALT_BASE * 4;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;

    // Map a halt code to its hold length in cycles.
    function automatic logic [CW-1:0] len_of(input logic [1:0] c);
        case (c)
            2'd0:    len_of = '0;
            2'd1:    len_of = CW'(HALT_BASE);
            2'd2:    len_of = CW'(HALT_BASE * 2);
            default: len_of = CW'(MAX_LEN);
        endcase
    endfunction

    // Count a hold down, or start a new one when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
        else if (req)        cnt <= len_of(code);
    end

    assign clk_en = (cnt == '0);

    AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(req && code != 2'd0)); // R8

    AST_ZERO_CODE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && code == 2'd0) |=> clk_en); // R8

endmodule

// File: rtl/pwrmode_ctl.sv
// Top of the low-power mode control register: decodes a byte write into stored
// fields, one-shot mode requests and a reset trigger, and drives the mode, pin-float,
// reset-pulse and CPU-clock-enable outputs. Assumes a single clock domain.
module pwrmode_ctl
    import pwrmode_pkg::*;
#(
    parameter int RST_LEN   = 3,
    parameter int HALT_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       cancel_i,
    input  logic       periph_req_i,
    output logic       mode_sleep_o,
    output logic       mode_stop_o,
    output logic       mode_tbt_o,
    output logic       pin_hiz_o,
    output logic       int_rst_o,
    output logic       cpu_clk_en_o
);

    logic       hiz;
    logic [1:0] halt_code;
    pm_mode_e   mode;
    logic       rst_fire;

    assign rst_fire = wr_en_i && !wr_data_i[BIT_RSTN];

    pwrmode_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_data   (wr_data_i),
        .hiz       (hiz),
        .halt_code (halt_code),
        .rd_data   (rd_data_o)
    );

    pwrmode_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .req_stop  (wr_data_i[BIT_STOP]),
        .req_tbt   (!wr_data_i[BIT_TBTN]),
        .req_sleep (wr_data_i[BIT_SLEEP]),
        .cancel    (cancel_i),
        .mode      (mode)
    );

    pwrmode_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (rst_fire),
        .pulse_o (int_rst_o)
    );

    pwrmode_hold #(.HALT_BASE(HALT_BASE)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (periph_req_i),
        .code   (halt_code),
        .clk_en (cpu_clk_en_o)
    );

    // Decode the mode and gate the pin-float control to the deep modes.
    always_comb begin
        mode_sleep_o = (mode == PM_SLEEP);
        mode_stop_o  = (mode == PM_STOP);
        mode_tbt_o   = (mode == PM_TBT);
        pin_hiz_o    = hiz && (mode == PM_STOP || mode == PM_TBT);
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_sleep_o, mode_stop_o, mode_tbt_o})); // R5

    AST_HIZ_DEEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz_o |-> (mode_stop_o || mode_tbt_o)); // R6

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_data_o == CTRL_RESET && !int_rst_o && cpu_clk_en_o
                           && !mode_sleep_o && !mode_stop_o && !mode_tbt_o)); // R1

    AST_RESET_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rst_o) |-> $past(wr_en_i && !wr_data_i[BIT_RSTN])); // R3

endmodule

// File: tb/pwrmode_ctl_bench.sv
module pwrmode_ctl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h18;
    logic [7:0] rd_data_o;
    logic       cancel_i = 1'b0;
    logic       periph_req_i = 1'b0;
    logic       mode_sleep_o, mode_stop_o, mode_tbt_o;
    logic       pin_hiz_o, int_rst_o, cpu_clk_en_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state: mode 0 run, 1 sleep, 2 stop, 3 tbt
    int         m_mode = 0;
    logic       m_hiz = 0;
    logic [1:0] m_halt = 0;
    int         m_rcnt = 0;
    int         m_hcnt = 0;

    pwrmode_ctl u_pwrmode_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .cancel_i(cancel_i), .periph_req_i(periph_req_i),
        .mode_sleep_o(mode_sleep_o), .mode_stop_o(mode_stop_o), .mode_tbt_o(mode_tbt_o),
        .pin_hiz_o(pin_hiz_o), .int_rst_o(int_rst_o), .cpu_clk_en_o(cpu_clk_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int halt_cycles(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 8;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd();
        return {2'b00, m_hiz, 2'b11, m_halt, 1'b0};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_hiz = 0; m_halt = 0; m_rcnt = 0; m_hcnt = 0;
    endtask

    task automatic model_step(input logic we, input logic [7:0] wd, input logic cn, input logic pr);
        if (m_hcnt != 0) m_hcnt--;
        else if (pr) m_hcnt = halt_cycles(m_halt);
        if (m_mode != 0) begin
            if (cn) m_mode = 0;
        end else if (we) begin
            if (wd[7]) m_mode = 2;
            else if (!wd[3]) m_mode = 3;
            else if (wd[6]) m_mode = 1;
        end
        if (we && !wd[4]) m_rcnt = 3;
        else if (m_rcnt != 0) m_rcnt--;
        if (we) begin
            m_hiz = wd[5];
            m_halt = wd[2:1];
        end
    endtask

    task automatic compare_all();
        check("R2 rd_data", rd_data_o, exp_rd());
        check("R3 int_rst", int_rst_o, m_rcnt != 0);
        check("R4 mode_sleep", mode_sleep_o, m_mode == 1);
        check("R4 mode_stop", mode_stop_o, m_mode == 2);
        check("R5 mode_tbt", mode_tbt_o, m_mode == 3);
        check("R6 pin_hiz", pin_hiz_o, m_hiz && (m_mode == 2 || m_mode == 3));
        check("R8 cpu_clk_en", cpu_clk_en_o, m_hcnt == 0);
    endtask

    // Apply inputs at the falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input logic we, input logic [7:0] wd, input logic cn, input logic pr);
        wr_en_i = we; wr_data_i = wd; cancel_i = cn; periph_req_i = pr;
        @(posedge clk);
        model_step(we, wd, cn, pr);
        @(negedge clk);
        wr_en_i = 0; cancel_i = 0; periph_req_i = 0;
        compare_all();
    endtask

    task automatic idle(); step(1'b0, 8'h18, 1'b0, 1'b0); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        model_reset();
        check("R1 rd_data", rd_data_o, 8'h18);
        check("R1 modes", {mode_sleep_o, mode_stop_o, mode_tbt_o}, 0);
        check("R1 int_rst", int_rst_o, 0);
        check("R1 clk_en", cpu_clk_en_o, 1);
        check("R1 pin_hiz", pin_hiz_o, 0);
        rst_n = 1'b1;
        idle();

        // R3 pulse length, and no pulse when bit 4 = 1
        step(1'b1, 8'h08, 1'b0, 1'b0);
        n = 0;
        while (int_rst_o && n < 10) begin n++; idle(); end
        check("R3 pulse length", n, 3);
        step(1'b1, 8'h18, 1'b0, 1'b0);
        check("R3 no pulse for bit4=1", int_rst_o, 0);

        // R2 read-back with all bits set, bit 0 ignored
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        check("R2 readback 0xFF write", rd_data_o, 8'h3E);
        check("R4 stop entered", mode_stop_o, 1);
        check("R6 pins float in stop", pin_hiz_o, 1);
        step(1'b0, 8'h18, 1'b1, 1'b0);
        check("R7 cancel leaves stop", mode_stop_o, 0);
        check("R7 pin float released", pin_hiz_o, 0);
        repeat (3) idle();

        // R7 cancel in run has no effect; sleep entry
        step(1'b0, 8'h18, 1'b1, 1'b0);
        check("R7 cancel in run", {mode_sleep_o, mode_stop_o, mode_tbt_o}, 0);
        step(1'b1, 8'h78, 1'b0, 1'b0);
        check("R4 sleep entered", mode_sleep_o, 1);
        check("R6 no float in sleep", pin_hiz_o, 0);
        step(1'b1, 8'h98, 1'b0, 1'b0);
        check("R5 request ignored while active", {mode_stop_o, mode_sleep_o}, 2'b01);
        step(1'b0, 8'h18, 1'b1, 1'b0);

        // R5 priority
        step(1'b1, 8'h40, 1'b0, 1'b0);
        check("R5 tbt over sleep", mode_tbt_o, 1);
        step(1'b0, 8'h18, 1'b1, 1'b0);
        step(1'b1, 8'hC0, 1'b0, 1'b0);
        check("R5 stop over all", mode_stop_o, 1);
        step(1'b0, 8'h18, 1'b1, 1'b0);
        repeat (4) idle();

        // R8 longest hold, with a mid-hold request ignored
        step(1'b1, 8'h1E, 1'b0, 1'b0);
        step(1'b0, 8'h18, 1'b0, 1'b1);
        n = 0;
        while (!cpu_clk_en_o && n < 100) begin
            n++;
            step(1'b0, 8'h18, 1'b0, (n == 10));
        end
        check("R8 hold 32 cycles", n, 32);
        step(1'b1, 8'h18, 1'b0, 1'b0);
        step(1'b0, 8'h18, 1'b0, 1'b1);
        check("R8 code 00 no hold", cpu_clk_en_o, 1);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            d = 8'($urandom);
            if ($urandom_range(3) != 0) d[4] = 1'b1;
            if ($urandom_range(2) != 0) d[3] = 1'b1;
            step($urandom_range(5) == 0, d, $urandom_range(6) == 0, $urandom_range(3) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule